// File: doc/BRIEF.md
# Two-Deep Stack Program Sequencer

This block is a compact 16-bit stack-machine core. A program counter addresses an external combinational program memory. The core latches each instruction word, decodes it and executes it against a top-of-stack register T and a next-of-stack register N. A parameterised spill stack sits below N. The instruction set covers stack shuffling (NOP, DUP, SWAP), a small arithmetic subset (add, double), switch input, a display output register, and two-word control transfers. A two-word transfer places its opcode in one word and an absolute target, or a literal, in the next.

Two of the control transfers branch on the level of a single push button. A program can therefore hold in a two-instruction loop until the button is released, and then until it is pressed again, without any interrupt logic. A typical program reads the switch bank, shows the value, waits for a press, computes a result from the stacked value and shows it.

Top module: `stack_seq_core`

## Requirements
- R1: Reset (`rst_n` low, asynchronous) clears the program counter, T, N, every spill cell and `disp_q` to zero, and holds `disp_stb` low.
- R2: The program counter loads a target when told to load, and loading takes priority over incrementing. Otherwise it increments by one when told to, and holds its value when given neither command.
- R3: A single-word instruction takes two cycles (fetch, execute) and a two-word instruction takes three (fetch, execute, operand). The display strobe of a display-store is high in the cycle after the edge that ends its execute cycle.
- R4: LIT (0x0100) pushes the word that follows it onto the stack and resumes at the word after that.
- R5: JMP (0x0101) sets the program counter to the word that follows it.
- R6: JZ (0x0102) pops T. It branches to the following word when the popped value was zero, and otherwise skips that word and continues after it.
- R7: Jump-on-pressed (0x010D) branches to its target while `btn` is 1, and jump-on-released (0x0109) branches while `btn` is 0. Each falls through past its target word otherwise.
- R8: DUP (0x0001) pushes a copy of T. SWAP (0x0002) exchanges T and N.
- R9: ADD (0x0010) replaces T with N+T modulo 2^16 and pops one entry. DOUBLE (0x0018) shifts T left by one, dropping bit 15.
- R10: READ-SWITCHES (0x0037) pushes the value on `sw_in`, sampled in its execute cycle.
- R11: SHOW (0x0038) copies T into `disp_q` and pulses `disp_stb` for exactly one cycle, leaving the stack unchanged. `disp_q` changes at no other time.
- R12: Any opcode not listed above, and 0x0000, executes as a two-cycle no-operation.
- R13: Values pushed below N come back in last-in, first-out order as entries are popped. The depth is set by `SPILL_DEPTH`, 4 by default.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_word | input | 16 | Program memory word at `prog_addr` |
| sw_in | input | 16 | Switch bank value |
| btn | input | 1 | Push button level, 1 when pressed |
| prog_addr | output | 16 | Program counter, the memory address |
| disp_q | output | 16 | Display register |
| disp_stb | output | 1 | One-cycle pulse when `disp_q` is written |

## Verification
The first fetch ends on the first rising edge after reset is released. From then on each single-word instruction occupies two edges and each two-word instruction three, so a display store finishes on a fixed edge number that can be counted from the program text. The bench counts rising edges after reset and stores each expected display value together with its due edge in a queue. A monitor samples on falling edges, pops an entry whenever the strobe is high, and compares both the value and the edge count. Waits on the button have no fixed length, so in that program only the values and their order are compared, and the port checks are made only after the loop has had more than enough cycles to settle.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;
  localparam int unsigned WORD_W = 16;
  typedef logic [WORD_W-1:0] word_t;

  localparam word_t OP_NOP  = 16'h0000;
  localparam word_t OP_DUP  = 16'h0001;
  localparam word_t OP_SWAP = 16'h0002;
  localparam word_t OP_ADD  = 16'h0010;
  localparam word_t OP_DBL  = 16'h0018;
  localparam word_t OP_RDSW = 16'h0037;
  localparam word_t OP_SHOW = 16'h0038;
  localparam word_t OP_LIT  = 16'h0100;
  localparam word_t OP_JMP  = 16'h0101;
  localparam word_t OP_JZ   = 16'h0102;
  localparam word_t OP_JBLO = 16'h0109;
  localparam word_t OP_JBHI = 16'h010D;

  typedef enum logic [1:0] {PH_FETCH, PH_EXEC, PH_OPND} phase_e;
  typedef enum logic [2:0] {SK_HOLD, SK_PUSH, SK_POP, SK_SWAP, SK_LOAD} stk_op_e;

  function automatic word_t f_sum(word_t a, word_t b);
    return a + b;
  endfunction

  function automatic word_t f_twice(word_t a);
    return {a[WORD_W-2:0], 1'b0};
  endfunction

  function automatic logic f_two_word(word_t op);
    return (op == OP_LIT) || (op == OP_JMP) || (op == OP_JZ) ||
           (op == OP_JBLO) || (op == OP_JBHI);
  endfunction
endpackage

// File: rtl/seq_pc.sv
module seq_pc
  import stack_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ld,
  input  logic  inc,
  input  word_t d,
  output word_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (ld)  q <= d;
    else if (inc) q <= q + word_t'(1);
  end
endmodule

// File: rtl/seq_stack.sv
module seq_stack
  import stack_seq_pkg::*;
#(
  parameter int unsigned SPILL_DEPTH = 4
) (
  input  logic    clk,
  input  logic    rst_n,
  input  stk_op_e op,
  input  word_t   val,
  output word_t   tos,
  output word_t   nos
);
  localparam int unsigned LAST = SPILL_DEPTH - 1;

  word_t [SPILL_DEPTH-1:0] spill;
  word_t [SPILL_DEPTH-1:0] push_in;
  word_t [SPILL_DEPTH-1:0] pop_in;

  for (genvar i = 0; i < SPILL_DEPTH; i++) begin : g_link
    if (i == 0) begin : g_head
      assign push_in[i] = nos;
    end else begin : g_body
      assign push_in[i] = spill[i-1];
    end
    if (i == LAST) begin : g_tail
      assign pop_in[i] = '0;
    end else begin : g_inner
      assign pop_in[i] = spill[i+1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tos   <= '0;
      nos   <= '0;
      spill <= '0;
    end else begin
      case (op)
        SK_PUSH: begin
          tos   <= val;
          nos   <= tos;
          spill <= push_in;
        end
        SK_POP: begin
          tos   <= val;
          nos   <= spill[0];
          spill <= pop_in;
        end
        SK_SWAP: begin
          tos <= nos;
          nos <= tos;
        end
        SK_LOAD: tos <= val;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import stack_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  word_t   prog_word,
  input  word_t   tos,
  input  word_t   nos,
  input  word_t   sw_in,
  input  logic    btn,
  output logic    pc_ld,
  output logic    pc_inc,
  output word_t   pc_tgt,
  output stk_op_e stk_op,
  output word_t   stk_val,
  output logic    fetch_ev,
  output logic    exec_ev,
  output word_t   disp_q,
  output logic    disp_stb
);
  phase_e phase_q, phase_d;
  word_t  ir_q;
  logic   disp_wr;
  logic   take;

  assign fetch_ev = (phase_q == PH_FETCH);
  assign exec_ev  = (phase_q == PH_EXEC);
  assign pc_tgt   = prog_word;

  always_comb begin
    phase_d = phase_q;
    pc_ld   = 1'b0;
    pc_inc  = 1'b0;
    stk_op  = SK_HOLD;
    stk_val = tos;
    disp_wr = 1'b0;
    take    = 1'b0;
    case (phase_q)
      PH_FETCH: begin
        pc_inc  = 1'b1;
        phase_d = PH_EXEC;
      end
      PH_EXEC: begin
        phase_d = f_two_word(ir_q) ? PH_OPND : PH_FETCH;
        case (ir_q)
          OP_DUP: begin
            stk_op  = SK_PUSH;
            stk_val = tos;
          end
          OP_SWAP: stk_op = SK_SWAP;
          OP_ADD: begin
            stk_op  = SK_POP;
            stk_val = f_sum(nos, tos);
          end
          OP_DBL: begin
            stk_op  = SK_LOAD;
            stk_val = f_twice(tos);
          end
          OP_RDSW: begin
            stk_op  = SK_PUSH;
            stk_val = sw_in;
          end
          OP_SHOW: disp_wr = 1'b1;
          default: ;
        endcase
      end
      PH_OPND: begin
        phase_d = PH_FETCH;
        case (ir_q)
          OP_LIT: begin
            stk_op  = SK_PUSH;
            stk_val = prog_word;
          end
          OP_JMP: take = 1'b1;
          OP_JZ: begin
            stk_op  = SK_POP;
            stk_val = nos;
            take    = (tos == '0);
          end
          OP_JBHI: take = btn;
          OP_JBLO: take = !btn;
          default: ;
        endcase
        pc_ld  = take;
        pc_inc = !take;
      end
      default: phase_d = PH_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_FETCH;
      ir_q    <= OP_NOP;
    end else begin
      phase_q <= phase_d;
      if (phase_q == PH_FETCH) ir_q <= prog_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_q   <= '0;
      disp_stb <= 1'b0;
    end else begin
      disp_stb <= disp_wr;
      if (disp_wr) disp_q <= tos;
    end
  end
endmodule

// File: rtl/stack_seq_core.sv
module stack_seq_core
  import stack_seq_pkg::*;
#(
  parameter int unsigned SPILL_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] prog_word,
  input  logic [WORD_W-1:0] sw_in,
  input  logic              btn,
  output logic [WORD_W-1:0] prog_addr,
  output logic [WORD_W-1:0] disp_q,
  output logic              disp_stb
);
  logic    pc_ld;
  logic    pc_inc;
  word_t   pc_tgt;
  stk_op_e stk_op;
  word_t   stk_val;
  word_t   tos;
  word_t   nos;
  logic    fetch_ev;
  logic    exec_ev;

  seq_pc u_pc (
    .clk   (clk),
    .rst_n (rst_n),
    .ld    (pc_ld),
    .inc   (pc_inc),
    .d     (pc_tgt),
    .q     (prog_addr)
  );

  seq_stack #(.SPILL_DEPTH(SPILL_DEPTH)) u_stack (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (stk_op),
    .val   (stk_val),
    .tos   (tos),
    .nos   (nos)
  );

  seq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .prog_word (prog_word),
    .tos       (tos),
    .nos       (nos),
    .sw_in     (sw_in),
    .btn       (btn),
    .pc_ld     (pc_ld),
    .pc_inc    (pc_inc),
    .pc_tgt    (pc_tgt),
    .stk_op    (stk_op),
    .stk_val   (stk_val),
    .fetch_ev  (fetch_ev),
    .exec_ev   (exec_ev),
    .disp_q    (disp_q),
    .disp_stb  (disp_stb)
  );
endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk
  import stack_seq_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  pc_ld,
  input logic  pc_inc,
  input word_t pc_tgt,
  input word_t prog_addr,
  input logic  fetch_ev,
  input logic  exec_ev,
  input word_t disp_q,
  input logic  disp_stb
);
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc_ld && !pc_inc) |=> $stable(prog_addr));

  a_r2_load_over_inc: assert property (@(posedge clk) disable iff (!rst_n)
    pc_ld |=> (prog_addr == $past(pc_tgt)));

  a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_inc && !pc_ld) |=> (prog_addr == $past(prog_addr) + word_t'(1)));

  a_r3_exec_follows_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ev |=> exec_ev);

  a_r11_strobe_after_exec: assert property (@(posedge clk) disable iff (!rst_n)
    disp_stb |-> $past(exec_ev));

  a_r11_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    disp_stb |=> !disp_stb);

  a_r11_display_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_stb |-> $stable(disp_q));
endmodule

bind stack_seq_core stack_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pc_ld     (pc_ld),
  .pc_inc    (pc_inc),
  .pc_tgt    (pc_tgt),
  .prog_addr (prog_addr),
  .fetch_ev  (fetch_ev),
  .exec_ev   (exec_ev),
  .disp_q    (disp_q),
  .disp_stb  (disp_stb)
);

// File: tb/stack_seq_core_test.sv
module stack_seq_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] sw_in = 16'h0000;
  logic        btn = 1'b0;
  logic [15:0] prog_word;
  logic [15:0] prog_addr;
  logic [15:0] disp_q;
  logic        disp_stb;

  logic [15:0] rom [64];
  assign prog_word = rom[prog_addr[5:0]];

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  typedef struct {
    logic [15:0] val;
    int          due;
    string       req;
  } exp_t;
  exp_t sb[$];

  stack_seq_core uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .prog_word (prog_word),
    .sw_in     (sw_in),
    .btn       (btn),
    .prog_addr (prog_addr),
    .disp_q    (disp_q),
    .disp_stb  (disp_stb)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_int(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  task automatic expect_show(logic [15:0] v, int due, string req);
    exp_t e;
    e.val = v;
    e.due = due;
    e.req = req;
    sb.push_back(e);
  endtask

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain(int lim);
    int k = 0;
    while (sb.size() != 0 && k < lim) begin
      @(negedge clk);
      k++;
    end
    check_int("R11 every expected display strobe seen", sb.size(), 0);
  endtask

  // Monitor: each strobe pops one expected display value and its due edge.
  always @(negedge clk) begin
    exp_t e;
    if (rst_n && disp_stb) begin
      if (sb.size() == 0) begin
        n_chk++;
        n_bad++;
        $display("FAIL R11 unexpected strobe actual=%h expected=none", disp_q);
      end else begin
        e = sb.pop_front();
        check(e.req, disp_q, e.val);
        if (e.due > 0) check_int({e.req, " (R3 due edge)"}, cyc, e.due);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  task automatic clear_rom();
    for (int i = 0; i < 64; i++) rom[i] = 16'h0000;
  endtask

  // Multiply-by-ten program with button handshakes.
  task automatic load_prog_a();
    clear_rom();
    rom[0]  = 16'h010D; rom[1]  = 16'h0000;
    rom[2]  = 16'h0109; rom[3]  = 16'h0002;
    rom[4]  = 16'h0037;
    rom[5]  = 16'h0038;
    rom[6]  = 16'h010D; rom[7]  = 16'h0006;
    rom[8]  = 16'h0109; rom[9]  = 16'h0008;
    rom[10] = 16'h0018;
    rom[11] = 16'h0001;
    rom[12] = 16'h0018;
    rom[13] = 16'h0018;
    rom[14] = 16'h0010;
    rom[15] = 16'h0038;
    rom[16] = 16'h0101; rom[17] = 16'h0000;
  endtask

  // Straight-line program exercising LIT, SWAP, JZ, NOP, DUP and spill.
  task automatic load_prog_b();
    clear_rom();
    rom[0]  = 16'h0100; rom[1]  = 16'h1234;
    rom[2]  = 16'h0100; rom[3]  = 16'h0005;
    rom[4]  = 16'h0002;
    rom[5]  = 16'h0038;
    rom[6]  = 16'h0010;
    rom[7]  = 16'h0038;
    rom[8]  = 16'h0100; rom[9]  = 16'h0000;
    rom[10] = 16'h0102; rom[11] = 16'h000E;
    rom[12] = 16'h0100; rom[13] = 16'hDEAD;
    rom[14] = 16'h00FF;
    rom[15] = 16'h0038;
    rom[16] = 16'h0100; rom[17] = 16'h0007;
    rom[18] = 16'h0102; rom[19] = 16'h0016;
    rom[20] = 16'h0018;
    rom[21] = 16'h0038;
    rom[22] = 16'h0001;
    rom[23] = 16'h0100; rom[24] = 16'h0001;
    rom[25] = 16'h0100; rom[26] = 16'h0002;
    rom[27] = 16'h0010;
    rom[28] = 16'h0010;
    rom[29] = 16'h0010;
    rom[30] = 16'h0038;
    rom[31] = 16'h0101; rom[32] = 16'h001F;
  endtask

  initial begin
    logic [15:0] n1, n2, t;
    n1 = 16'h003B;
    n2 = 16'h1999;

    // Phase A
    load_prog_a();
    sw_in = n1;
    btn   = 1'b0;
    hold(3);
    check("R1 reset program address", prog_addr, 16'h0000);
    check("R1 reset display", disp_q, 16'h0000);
    check("R1 reset strobe", {15'd0, disp_stb}, 16'h0000);

    expect_show(n1, 0, "R10 switches shown");
    expect_show(16'(n1 * 16'd10), 0, "R9 ten times first value");
    expect_show(n2, 0, "R10 second switches shown");
    expect_show(16'(n2 * 16'd10), 0, "R9 ten times second value with wrap");

    rst_n = 1'b1;
    hold(12);
    check("R7 released button holds loop, no display", disp_q, 16'h0000);
    btn = 1'b1; hold(12);
    check("R7 press releases first wait", disp_q, n1);
    btn = 1'b0; hold(12);
    check("R11 display unchanged while waiting", disp_q, n1);
    btn = 1'b1; hold(24);
    btn = 1'b0; sw_in = n2; hold(12);
    btn = 1'b1; hold(12);
    btn = 1'b0; hold(12);
    btn = 1'b1; hold(24);
    btn = 1'b0; hold(6);
    drain(100);
    check("R9 final product on display", disp_q, 16'hFFFA);

    // Phase B
    @(negedge clk);
    rst_n = 1'b0;
    hold(2);
    check("R1 mid-run reset clears display", disp_q, 16'h0000);
    check("R1 mid-run reset clears address", prog_addr, 16'h0000);
    load_prog_b();
    sw_in = 16'hFFFF;

    t = 16'h1234;
    expect_show(t, 10, "R8 SWAP brings first literal to top (R4 LIT)");
    t = t + 16'h0005;
    expect_show(t, 14, "R9 ADD of N and T");
    expect_show(t, 24, "R6 JZ on zero taken, R12 unknown opcode as NOP");
    t = {t[14:0], 1'b0};
    expect_show(t, 34, "R6 JZ on nonzero falls through, R9 DOUBLE");
    t = t + (t + 16'h0003);
    expect_show(t, 50, "R13 spilled copies return LIFO, R8 DUP");

    rst_n = 1'b1;
    drain(80);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      n_chk++;
      if (prog_addr != 16'h001F && prog_addr != 16'h0020) begin
        n_bad++;
        $display("FAIL R5 JMP self-loop actual=%h expected=001F or 0020", prog_addr);
      end
    end
    check("R11 display kept while parked", disp_q, t);
    finish_run();
  end
endmodule